// File: doc/BRIEF.md
# MSI Event Queue Record Writer

This block turns an incoming message-signalled interrupt (MSI) memory write into a 64-byte event record and aims it at one of several circular event queues in memory. The MSI number is taken from the low byte of the MSI data. A per-MSI mapping table decides whether that MSI is in use and which queue it feeds. When the MSI is accepted, the block works out where the record goes, builds the record and issues it as one full-line write command on the cycle after the MSI arrives. It also advances the queue's tail pointer and marks the MSI as pending.

Software has three simple write ports. The first programs the mapping table. The second clears pending flags. The third moves a queue's head pointer as records are consumed. The queue region base address is a static input. An MSI is dropped without any side effect in three cases: it is unmapped, it is still pending, or its queue is full.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset no write command is issued, every MSI is unmapped and not pending, and all head and tail pointers are 0.
- R2: An MSI whose number (msi_data[7:0]) is unmapped produces no write and changes no state.
- R3: An MSI whose pending flag is set is dropped. Once the flag is cleared through the clear port, the same MSI is delivered again.
- R4: An MSI is dropped when the target queue's 7-bit tail plus one equals its head, modulo 128.
- R5: The record address is base_addr + queue*8192 + tail*64.
- R6: Line bits [511:448] hold record word 0. From the top down, word 0 contains: a 0 bit; a 7-bit format code, which is 1011000 when msi_addr[63:32] is zero and 1111000 otherwise; a 10-bit length of 1; msi_addr[15:2]; the 16-bit requester ID; and data bytes {d+1, d}, where d = msi_data[7:0].
- R7: Line bits [447:384] hold record word 1, which is msi_addr[63:16] followed by data bytes {d+3, d+2}, with byte sums taken modulo 256. Line bits [383:0] are zero.
- R8: A delivered MSI raises wr_valid for exactly one cycle, on the cycle after msi_valid. On that cycle wr_tag equals the MSI tag, wr_mask is all zero (all bytes valid) and wr_last is 1.
- R9: Each delivery increments the queue's tail by one, wrapping from 127 to 0. Dropped MSIs leave the tail unchanged.
- R10: When a pending clear and a delivery hit the same MSI in the same cycle, the flag stays set.
- R11: A head write takes effect on the next MSI and moves the point at which the queue counts as full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 64 | Base address of the queue region |
| msi_valid | input | 1 | MSI write present this cycle |
| msi_addr | input | 64 | MSI target address |
| msi_data | input | 32 | MSI data; low byte is the MSI number |
| msi_rid | input | 16 | Requester ID |
| msi_tag | input | 8 | Request tag, echoed on the write |
| map_we | input | 1 | Mapping table write strobe |
| map_idx | input | 8 | MSI number to map |
| map_valid | input | 1 | Mapping enable for map_idx |
| map_queue | input | Q_W | Queue number for map_idx |
| pend_clr | input | 1 | Pending flag clear strobe |
| pend_clr_idx | input | 8 | MSI number whose flag is cleared |
| head_we | input | 1 | Head pointer write strobe |
| head_idx | input | Q_W | Queue whose head is written |
| head_val | input | PTR_W | New head value |
| wr_valid | output | 1 | Line write command valid |
| wr_addr | output | 64 | Line write address |
| wr_data | output | 512 | Line data, word 0 in the top bits |
| wr_mask | output | 8 | Byte mask, zero meaning all valid |
| wr_last | output | 1 | Last-packet flag |
| wr_tag | output | 8 | Echoed tag |

## Verification
The bench builds the block with Q_W=2, which gives four queues, and keeps the default 7-bit pointers. With that setup it can map and fire all 256 MSI numbers, and it can drive real queues all the way to full in a few hundred cycles. Full sweeps reach every drop reason and the tail wrap from 127 to 0, and they alternate between 32-bit and 64-bit MSI addresses. Expected records and addresses come from a small arithmetic model of the queues kept inside the bench.

// File: rtl/msi_evq_writer.sv
module msi_evq_writer #(
  parameter int Q_W   = 3,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      base_addr,
  input  logic             msi_valid,
  input  logic [63:0]      msi_addr,
  input  logic [31:0]      msi_data,
  input  logic [15:0]      msi_rid,
  input  logic [7:0]       msi_tag,
  input  logic             map_we,
  input  logic [7:0]       map_idx,
  input  logic             map_valid,
  input  logic [Q_W-1:0]   map_queue,
  input  logic             pend_clr,
  input  logic [7:0]       pend_clr_idx,
  input  logic             head_we,
  input  logic [Q_W-1:0]   head_idx,
  input  logic [PTR_W-1:0] head_val,
  output logic             wr_valid,
  output logic [63:0]      wr_addr,
  output logic [511:0]     wr_data,
  output logic [7:0]       wr_mask,
  output logic             wr_last,
  output logic [7:0]       wr_tag
);
  localparam int NUM_Q  = 1 << Q_W;
  localparam int REC_SH = 6;
  localparam int Q_SH   = REC_SH + PTR_W;

  logic [255:0]     mapped, pending;
  logic [Q_W-1:0]   qsel [256];
  logic [PTR_W-1:0] head [NUM_Q];
  logic [PTR_W-1:0] tail [NUM_Q];

  logic [7:0]       num;
  logic [Q_W-1:0]   q;
  logic [PTR_W-1:0] t;
  logic             full, deliver;
  logic [7:0]       d;
  logic [6:0]       fmt;
  logic [63:0]      w0, w1, rec_addr;

  assign num     = msi_data[7:0];
  assign q       = qsel[num];
  assign t       = tail[q];
  assign full    = (t + PTR_W'(1)) == head[q];
  assign deliver = msi_valid && mapped[num] && !pending[num] && !full;

  assign d   = msi_data[7:0];
  assign fmt = (msi_addr[63:32] == 32'd0) ? 7'b1011000 : 7'b1111000;
  assign w0  = {1'b0, fmt, 10'd1, msi_addr[15:2], msi_rid, d + 8'd1, d};
  assign w1  = {msi_addr[63:16], d + 8'd3, d + 8'd2};
  assign rec_addr = base_addr + (64'(q) << Q_SH) + (64'(t) << REC_SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped  <= '0;
      pending <= '0;
      for (int i = 0; i < 256; i++) qsel[i] <= '0;
      for (int i = 0; i < NUM_Q; i++) begin
        head[i] <= '0;
        tail[i] <= '0;
      end
    end else begin
      if (map_we) begin
        mapped[map_idx] <= map_valid;
        qsel[map_idx]   <= map_queue;
      end
      if (pend_clr) pending[pend_clr_idx] <= 1'b0;
      if (deliver)  pending[num] <= 1'b1;
      if (head_we)  head[head_idx] <= head_val;
      if (deliver)  tail[q] <= t + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_tag   <= '0;
    end else begin
      wr_valid <= deliver;
      if (deliver) begin
        wr_addr <= rec_addr;
        wr_data <= {w0, w1, 384'd0};
        wr_tag  <= msi_tag;
      end
    end
  end

  assign wr_mask = 8'h00;
  assign wr_last = wr_valid;
endmodule

// File: rtl/msi_evq_writer_chk.sv
module msi_evq_writer_chk #(
  parameter int Q_W   = 3,
  parameter int PTR_W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [63:0]  base_addr,
  input logic         msi_valid,
  input logic [63:0]  msi_addr,
  input logic [31:0]  msi_data,
  input logic [7:0]   msi_tag,
  input logic         wr_valid,
  input logic [63:0]  wr_addr,
  input logic [511:0] wr_data,
  input logic [7:0]   wr_tag
);
  localparam logic [63:0] SPAN = 64'(1 << Q_W) << (6 + PTR_W);

  // R8
  wr_follows_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(msi_valid) && wr_tag == $past(msi_tag));

  // R3
  no_repeat_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> $past(msi_data[7:0]) != $past(msi_data[7:0], 2));

  // R5
  addr_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[5:0] == base_addr[5:0] && (wr_addr - base_addr) < SPAN);

  // R6
  fmt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[511] == 1'b0 && wr_data[503:494] == 10'd1 &&
      wr_data[510:504] == (($past(msi_addr[63:32]) == 32'd0) ? 7'b1011000 : 7'b1111000));

  // R7
  tail_words_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[383:0] == '0 && wr_data[447:400] == $past(msi_addr[63:16]));
endmodule

bind msi_evq_writer msi_evq_writer_chk #(.Q_W(Q_W), .PTR_W(PTR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .msi_valid(msi_valid),
  .msi_addr(msi_addr), .msi_data(msi_data), .msi_tag(msi_tag),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag));

// File: tb/test_msi_evq_writer.sv
`timescale 1ns/1ps
module test_msi_evq_writer;
  localparam int Q_W = 2;
  localparam int PTR_W = 7;
  localparam logic [63:0] BASE = 64'h0000_0040_0010_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] base_addr = BASE;
  logic msi_valid = 0; logic [63:0] msi_addr = '0; logic [31:0] msi_data = '0;
  logic [15:0] msi_rid = '0; logic [7:0] msi_tag = '0;
  logic map_we = 0; logic [7:0] map_idx = '0; logic map_valid = 0; logic [Q_W-1:0] map_queue = '0;
  logic pend_clr = 0; logic [7:0] pend_clr_idx = '0;
  logic head_we = 0; logic [Q_W-1:0] head_idx = '0; logic [PTR_W-1:0] head_val = '0;
  logic wr_valid, wr_last; logic [63:0] wr_addr; logic [511:0] wr_data;
  logic [7:0] wr_mask, wr_tag;

  always #2.5 clk = ~clk;

  msi_evq_writer #(.Q_W(Q_W), .PTR_W(PTR_W)) i_msi_evq_writer (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  bit mv [256]; int mq [256]; bit pd [256];
  bit [6:0] hd [4]; bit [6:0] tl [4];

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic map(int i, bit v, int qn);
    map_we = 1; map_idx = 8'(i); map_valid = v; map_queue = Q_W'(qn);
    @(negedge clk); map_we = 0;
    mv[i] = v; mq[i] = qn;
  endtask

  task automatic clr(int i);
    pend_clr = 1; pend_clr_idx = 8'(i);
    @(negedge clk); pend_clr = 0;
    pd[i] = 0;
  endtask

  task automatic set_head(int qn, int v);
    head_we = 1; head_idx = Q_W'(qn); head_val = 7'(v);
    @(negedge clk); head_we = 0;
    hd[qn] = 7'(v);
  endtask

  task automatic send(logic [63:0] a, logic [31:0] dt, logic [15:0] rid, logic [7:0] tag,
                      bit clr_same, output bit delivered);
    int n, qn; bit ok; string why;
    logic [7:0] b; logic [63:0] ea, e0, e1; logic [511:0] ed;
    n = dt[7:0]; qn = mq[n];
    why = "R9";
    ok = 1;
    if (!mv[n]) begin ok = 0; why = "R2"; end
    else if (pd[n]) begin ok = 0; why = "R3"; end
    else if (7'(tl[qn] + 1) == hd[qn]) begin ok = 0; why = "R4"; end
    b = dt[7:0];
    ea = BASE + 64'(qn) * 64'd8192 + 64'(tl[qn]) * 64'd64;
    e0 = 64'(a[63:32] == 0 ? 7'h58 : 7'h78) << 56;
    e0 = e0 | (64'd1 << 46) | (64'(a[15:2]) << 32) | (64'(rid) << 16)
            | (64'(8'(b + 1)) << 8) | 64'(b);
    e1 = (64'(a[63:16]) << 16) | (64'(8'(b + 3)) << 8) | 64'(8'(b + 2));
    ed = {e0, e1, 384'd0};
    msi_valid = 1; msi_addr = a; msi_data = dt; msi_rid = rid; msi_tag = tag;
    if (clr_same) begin pend_clr = 1; pend_clr_idx = 8'(n); end
    @(negedge clk);
    msi_valid = 0; pend_clr = 0;
    chk(wr_valid == ok, why, 512'(wr_valid), 512'(ok));
    if (ok && wr_valid) begin
      chk(wr_addr == ea, "R5/R9 addr", 512'(wr_addr), 512'(ea));
      chk(wr_data[511:448] == e0, "R6 word0", 512'(wr_data[511:448]), 512'(e0));
      chk(wr_data[447:0] == ed[447:0], "R7 word1/zero", 512'(wr_data[447:0]), 512'(ed[447:0]));
      chk(wr_tag == tag && wr_mask == 8'h00 && wr_last == 1'b1, "R8 tag/mask/last",
          512'({wr_tag, wr_mask, 7'd0, wr_last}), 512'({tag, 8'h00, 8'h01}));
    end
    if (ok) begin pd[n] = 1; tl[qn] = 7'(tl[qn] + 1); end
    else if (clr_same) pd[n] = 0;
    delivered = ok;
  endtask

  task automatic fire(int i, bit clr_same, output bit dl);
    logic [63:0] a;
    a = i[0] ? {32'h0, 32'hFEE0_0000 | (32'(i) << 2)} : {32'h0000_0001 + 32'(i), 32'h0ABC_0000 | (32'(i) << 2)};
    send(a, {8'(i) ^ 8'h5A, 8'(i * 3), 8'h33, 8'(i)}, 16'(i * 257), 8'(i + 7), clr_same, dl);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mv[i] = 0; mq[i] = 0; pd[i] = 0; end
    for (int i = 0; i < 4; i++) begin hd[i] = 0; tl[i] = 0; end
    repeat (3) @(negedge clk);
    chk(wr_valid == 0, "R1 reset valid", 512'(wr_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_valid == 0, "R1 idle", 512'(wr_valid), 0);
    begin
      bit dl;
      for (int i = 0; i < 256; i += 37) fire(i, 0, dl);
      for (int i = 0; i < 256; i++) map(i, (i % 16) != 15, i % 4);
      for (int i = 0; i < 256; i++) fire(i, 0, dl);
      for (int i = 0; i < 256; i++) fire(i, 0, dl);
      for (int i = 0; i < 256; i++) clr(i);
      for (int i = 0; i < 256; i++) fire(i, 0, dl);
      chk(tl[0] == 7'd127, "R4 queue0 filled", 512'(tl[0]), 127);
      clr(0);
      fire(0, 0, dl);
      chk(dl == 0, "R4 full drop", 512'(dl), 0);
      set_head(0, 10);
      for (int k = 0; k < 12; k++) begin
        clr(4 * (k % 3));
        fire(4 * (k % 3), 0, dl);
      end
      chk(tl[0] == 7'd9, "R11 R9 wrap to full", 512'(tl[0]), 9);
      set_head(1, 64);
      clr(1); clr(5);
      fire(1, 1, dl);
      chk(dl == 1, "R10 delivered", 512'(dl), 1);
      fire(1, 0, dl);
      chk(dl == 0, "R10 set wins", 512'(dl), 0);
      clr(9);
      fire(5, 0, dl);
      fire(1, 0, dl);
      chk(dl == 0, "R3 other clear no effect", 512'(dl), 0);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (200000) @(posedge clk);
        errors++; checks++; $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule